// File: doc/BRIEF.md
# Control-Bus SPI Register Slave with Navigation Packet

This block is the control-side serial slave of a swipe-type finger sensor. The host talks to it over a low-speed SPI link in 8-bit words. A word with bit 7 set is a command and picks a register and a direction. A word with bit 7 clear carries write data or serves as a dummy while read data is shifted out. Behind the link sits a small register file. It holds the operating mode, the interrupt enables, heating, navigation, click and movement-threshold settings. It also holds a status register that clears when read and a three-byte navigation packet laid out like a PS/2 mouse report.

The sensing logic feeds the block with single-cycle event pulses: a click pulse and a movement pulse carrying signed per-slice X and Y deltas. The deltas are summed into sign-magnitude counters until the host reads the navigation packet. The block drives an active-low interrupt line whenever an enabled status bit is set. The SPI pins are sampled with the block's own clock, so SCK must run well below that clock. RST is asynchronous and is the only way to realign the word framing.

Top module: `ctl_spi_slave`

## Requirements
- R1: A command word is {1, rd, addr[3:0], x, x}, with rd=1 meaning a read. After a write command, the next word with bit 7 = 0 writes its bits 6..0 to the addressed register. After a read command, the next word returns {0, reg[6:0]}. The addresses are MODE=1, IRQEN=2, HEAT=3, NAVCFG=4, CLKCFG=5 and MOVTHR=6.
- R2: Words are 8 bits, MSB first, with SCK idling high. MISO changes after SCK falls and MOSI is taken on SCK rise. The bit count survives a deselect, so only RST realigns the framing. miso_oe is high exactly while ss_n is low.
- R3: After RST, MODE reads 0x04, NAVCFG reads 0x40, CLKCFG reads 0x15, the other registers read 0x00, and irq_n is high.
- R4: Reading address 0 returns the status byte, with click in bit 7, movement in bit 6 and read error in bit 3. The read then clears the status byte, which releases irq_n.
- R5: irq_n is low while any of these pairs is set: status bit 7 with IRQEN bit 6, status bit 6 with IRQEN bit 5, or status bit 3 with IRQEN bit 2.
- R6: A read of address 8 returns three bytes on successive dummy words: the general byte, then |X|, then |Y|. All three then read as cleared.
- R7: The general byte is {Y overflow, X overflow, Y negative, X negative, 1, 0, click, 0}. A status read does not clear its click bit.
- R8: Deltas accumulate per axis. A magnitude that would pass 255 is held at 255 and sets the sticky overflow bit of that axis.
- R9: When a movement pulse leaves |X| or |Y| strictly above MOVTHR shifted left by one, status bit 6 is set. A value equal to the threshold does not set it.
- R10: A written MODE value with bit 6 (acquisition) set together with bit 5 or bit 4 is stored with bit 6 cleared.
- R11: Writes to address 0, address 8 or any reserved address change nothing. A data word with no write pending is ignored.
- R12: A read command to an address other than 0..6 or 8 returns 0x00 and sets status bit 3.
- R13: Click pulses count only when MODE bit 4 = 1 and MODE bit 2 = 0. Movement pulses count only when MODE bit 5 = 1 and MODE bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the SPI pins |
| rst | input | 1 | Asynchronous reset, active high |
| sck | input | 1 | SPI clock from the host, idles high |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | High while MISO should be driven |
| irq_n | output | 1 | Interrupt request, active low |
| click_ev | input | 1 | One-cycle click detection pulse |
| mov_vld | input | 1 | One-cycle movement pulse qualifying the deltas |
| mov_dx | input | DELTA_W | Signed X delta |
| mov_dy | input | DELTA_W | Signed Y delta |

## Verification
The bench builds the block with DELTA_W = 8 and SYNC_STAGES = 2. Deltas of up to ±127 let three pulses drive both axes past the 255 clamp, with X and Y overflowing in opposite directions. Small deltas land exactly on a threshold of 10 and one past it. With an SCK half-period of eight block clocks, the two-stage synchronizer still leaves MISO settled well before each rising edge. The same timing lets the bench split one command across two selects to show that the framing persists until RST.

// File: rtl/ctl_spi_slave.sv
module ctl_spi_slave #(
  parameter int DELTA_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck,
  input  logic               ss_n,
  input  logic               mosi,
  output logic               miso,
  output logic               miso_oe,
  output logic               irq_n,
  input  logic               click_ev,
  input  logic               mov_vld,
  input  logic [DELTA_W-1:0] mov_dx,
  input  logic [DELTA_W-1:0] mov_dy
);

  localparam int SW = ((DELTA_W > 9) ? DELTA_W : 9) + 2;
  localparam logic signed [SW-1:0] LIM = SW'(255);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_t;

  logic [SYNC_STAGES-1:0] sck_sy, ss_sy, mosi_sy;
  logic sck_d;
  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sck_sy  <= '1;
      ss_sy   <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], sck};
      ss_sy   <= {ss_sy[SYNC_STAGES-2:0], ss_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sck_d   <= sck_sy[SYNC_STAGES-1];
    end

  wire sck_r  = sck_sy[SYNC_STAGES-1];
  wire sel    = ~ss_sy[SYNC_STAGES-1];
  wire rise   = sel & sck_r & ~sck_d;
  wire fall   = sel & ~sck_r & sck_d;

  logic [6:0] rx_sr;
  logic [2:0] bit_cnt;
  logic [7:0] tx_sr;
  st_t        st;
  logic [3:0] addr;
  logic [1:0] nav_idx;
  logic [6:0] r_mode, r_en, r_heat, r_nav, r_click, r_mov;
  logic       st_click, st_mov, st_rderr, nav_click, ovf_x, ovf_y;
  logic signed [SW-1:0] acc_x, acc_y;
  logic [7:0] hold_x, hold_y;

  wire [7:0] rx_word  = {rx_sr, mosi_sy[SYNC_STAGES-1]};
  wire       byte_done = rise & (bit_cnt == 3'd7);
  wire       cmd      = byte_done & rx_word[7];
  wire       cmd_rd   = cmd & rx_word[6];
  wire [3:0] caddr    = rx_word[5:2];
  wire       ld_status = cmd_rd & (caddr == 4'd0);
  wire       ld_nav    = cmd_rd & (caddr == 4'd8);
  wire       rderr_set = cmd_rd & (caddr == 4'd7 || caddr > 4'd8);
  wire       wr_data   = byte_done & ~rx_word[7] & (st == S_WR);

  wire osc_on = ~r_mode[2];
  wire clk_ok = click_ev & r_mode[4] & osc_on;
  wire mov_ok = mov_vld & r_mode[5] & osc_on;

  function automatic logic signed [SW-1:0] clampf(input logic signed [SW-1:0] s);
    if (s > LIM) return LIM;
    else if (s < -LIM) return -LIM;
    else return s;
  endfunction

  function automatic logic [7:0] magf(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] a;
    a = (s < 0) ? -s : s;
    return a[7:0];
  endfunction

  wire signed [SW-1:0] dx_e  = {{(SW-DELTA_W){mov_dx[DELTA_W-1]}}, mov_dx};
  wire signed [SW-1:0] dy_e  = {{(SW-DELTA_W){mov_dy[DELTA_W-1]}}, mov_dy};
  wire signed [SW-1:0] sum_x = (ld_nav ? '0 : acc_x) + (mov_ok ? dx_e : '0);
  wire signed [SW-1:0] sum_y = (ld_nav ? '0 : acc_y) + (mov_ok ? dy_e : '0);
  wire signed [SW-1:0] nx    = clampf(sum_x);
  wire signed [SW-1:0] ny    = clampf(sum_y);
  wire [7:0] thr     = {r_mov, 1'b0};
  wire       mov_hit = mov_ok & ((magf(nx) > thr) | (magf(ny) > thr));

  wire [7:0] status_b = {st_click, st_mov, 2'b00, st_rderr, 3'b000};
  wire [7:0] gen_b    = {ovf_y, ovf_x, acc_y < 0, acc_x < 0, 1'b1, 1'b0, nav_click, 1'b0};

  logic [7:0] rd_val;
  always_comb
    case (caddr)
      4'd0:    rd_val = status_b;
      4'd1:    rd_val = {1'b0, r_mode};
      4'd2:    rd_val = {1'b0, r_en};
      4'd3:    rd_val = {1'b0, r_heat};
      4'd4:    rd_val = {1'b0, r_nav};
      4'd5:    rd_val = {1'b0, r_click};
      4'd6:    rd_val = {1'b0, r_mov};
      4'd8:    rd_val = gen_b;
      default: rd_val = 8'h00;
    endcase

  wire [6:0] mode_wr = (rx_word[6] & (rx_word[5] | rx_word[4])) ? {1'b0, rx_word[5:0]} : rx_word[6:0];

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      rx_sr <= '0; bit_cnt <= '0; tx_sr <= '0; miso <= 1'b0;
      st <= S_IDLE; addr <= '0; nav_idx <= '0;
      hold_x <= '0; hold_y <= '0;
    end else begin
      if (rise) begin
        rx_sr   <= rx_word[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (fall) begin
        miso  <= tx_sr[7];
        tx_sr <= {tx_sr[6:0], 1'b0};
      end
      if (byte_done) begin
        if (rx_word[7]) begin
          addr    <= caddr;
          st      <= rx_word[6] ? S_RD : S_WR;
          tx_sr   <= rx_word[6] ? rd_val : 8'h00;
          nav_idx <= ld_nav ? 2'd1 : 2'd0;
          if (ld_nav) begin
            hold_x <= magf(acc_x);
            hold_y <= magf(acc_y);
          end
        end else if (st == S_RD) begin
          case (nav_idx)
            2'd1:    begin tx_sr <= hold_x; nav_idx <= 2'd2; end
            2'd2:    begin tx_sr <= hold_y; nav_idx <= 2'd0; end
            default: tx_sr <= 8'h00;
          endcase
        end else begin
          st    <= S_IDLE;
          tx_sr <= 8'h00;
        end
      end
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      r_mode <= 7'h04; r_en <= '0; r_heat <= '0;
      r_nav <= 7'h40; r_click <= 7'h15; r_mov <= '0;
    end else if (wr_data)
      case (addr)
        4'd1: r_mode  <= mode_wr;
        4'd2: r_en    <= rx_word[6:0];
        4'd3: r_heat  <= rx_word[6:0];
        4'd4: r_nav   <= rx_word[6:0];
        4'd5: r_click <= rx_word[6:0];
        4'd6: r_mov   <= rx_word[6:0];
        default: ;
      endcase

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      st_click <= 1'b0; st_mov <= 1'b0; st_rderr <= 1'b0;
      nav_click <= 1'b0; ovf_x <= 1'b0; ovf_y <= 1'b0;
      acc_x <= '0; acc_y <= '0;
    end else begin
      st_click  <= (st_click & ~ld_status) | clk_ok;
      st_mov    <= (st_mov & ~ld_status) | mov_hit;
      st_rderr  <= (st_rderr & ~ld_status) | rderr_set;
      nav_click <= (nav_click & ~ld_nav) | clk_ok;
      ovf_x     <= (ovf_x & ~ld_nav) | (mov_ok & (sum_x != nx));
      ovf_y     <= (ovf_y & ~ld_nav) | (mov_ok & (sum_y != ny));
      acc_x     <= nx;
      acc_y     <= ny;
    end

  assign irq_n   = ~((st_click & r_en[6]) | (st_mov & r_en[5]) | (st_rderr & r_en[2]));
  assign miso_oe = ~ss_n;

  a_r4_irq_release: assert property (@(posedge clk) disable iff (rst)
    (ld_status && !clk_ok && !mov_hit) |=> irq_n);
  a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
    !(r_mode[6] && (r_mode[5] || r_mode[4])));
  a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(miso));
  a_r2_count_held: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(bit_cnt));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_x && !ld_nav) |=> ovf_x);
  a_r8_mag_cap: assert property (@(posedge clk) disable iff (rst)
    (acc_x <= LIM) && (acc_x >= -LIM) && (acc_y <= LIM) && (acc_y >= -LIM));
  a_r13_gate: assert property (@(posedge clk) disable iff (rst)
    (r_mode[2] && !ld_nav) |=> $stable(acc_x) && $stable(nav_click));

endmodule

// File: tb/ctl_spi_slave_tb_top.sv
module ctl_spi_slave_tb_top;
  localparam int DW = 8;
  localparam int HP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b1, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, irq_n;
  logic click_ev = 1'b0, mov_vld = 1'b0;
  logic [DW-1:0] mov_dx = '0, mov_dy = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_spi_slave #(.DELTA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .irq_n(irq_n),
    .click_ev(click_ev), .mov_vld(mov_vld), .mov_dx(mov_dx), .mov_dy(mov_dy));

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial forever begin
    wait (got_q.size() > 0);
    begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g === e, t, g, e);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] v, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; mosi = v[i];
      cyc(HP);
      r[i] = miso;
      sck = 1'b1;
      cyc(HP);
    end
  endtask

  task automatic sel();   ss_n = 1'b0; cyc(HP); endtask
  task automatic desel(); cyc(HP); ss_n = 1'b1; cyc(2*HP); endtask

  task automatic xfer(input logic [7:0] v, input bit chk, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    spi_bits(v, 8, r);
    if (chk) begin
      exp_q.push_back(exp); tag_q.push_back(tag); got_q.push_back(r);
    end
  endtask

  function automatic logic [7:0] cmdw(input bit rd, input logic [3:0] a);
    return {1'b1, rd, a, 2'b00};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [6:0] d);
    sel(); xfer(cmdw(0, a), 0, 0, ""); xfer({1'b0, d}, 0, 0, ""); desel();
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    sel(); xfer(cmdw(1, a), 0, 0, ""); xfer(8'h00, 1, e, tag); desel();
  endtask

  task automatic rd_nav(input logic [7:0] g, input logic [7:0] x, input logic [7:0] y, input string tag);
    sel(); xfer(cmdw(1, 4'd8), 0, 0, "");
    xfer(8'h00, 1, g, {tag, " general"});
    xfer(8'h00, 1, x, {tag, " X"});
    xfer(8'h00, 1, y, {tag, " Y"});
    desel();
  endtask

  task automatic mov(input logic [7:0] dx, input logic [7:0] dy);
    mov_dx = dx; mov_dy = dy; mov_vld = 1'b1; cyc(1); mov_vld = 1'b0; cyc(4);
  endtask

  task automatic clk_pulse();
    click_ev = 1'b1; cyc(1); click_ev = 1'b0; cyc(4);
  endtask

  initial begin
    cyc(100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    cyc(5); rst = 1'b0; cyc(5);
    check(irq_n === 1'b1, "R3 irq_n after reset", {7'b0, irq_n}, 8'h01);
    check(miso_oe === 1'b0, "R2 miso_oe deselected", {7'b0, miso_oe}, 8'h00);
    rd(4'd1, 8'h04, "R3 MODE reset");
    rd(4'd4, 8'h40, "R3 NAVCFG reset");
    rd(4'd5, 8'h15, "R3 CLKCFG reset");
    rd(4'd2, 8'h00, "R3 IRQEN reset");
    rd(4'd0, 8'h00, "R3 status reset");

    wr(4'd1, 7'h30);
    rd(4'd1, 8'h30, "R1 MODE write");
    wr(4'd1, 7'h50);
    rd(4'd1, 8'h10, "R10 acq+click masked");
    wr(4'd1, 7'h40);
    rd(4'd1, 8'h40, "R10 acq alone kept");
    wr(4'd1, 7'h30);
    wr(4'd2, 7'h64);
    wr(4'd6, 7'h05);
    rd(4'd6, 8'h05, "R1 MOVTHR write");

    clk_pulse();
    check(irq_n === 1'b0, "R5 click irq", {7'b0, irq_n}, 8'h00);
    rd(4'd0, 8'h80, "R4 status click");
    check(irq_n === 1'b1, "R4 irq released", {7'b0, irq_n}, 8'h01);
    rd(4'd0, 8'h00, "R4 status cleared");
    rd_nav(8'h0A, 8'h00, 8'h00, "R7 click kept");
    rd_nav(8'h08, 8'h00, 8'h00, "R6 cleared");

    mov(8'd7, -8'sd3);
    mov(8'd3, 8'd0);
    check(irq_n === 1'b1, "R9 equal to threshold", {7'b0, irq_n}, 8'h01);
    mov(8'd1, 8'd0);
    check(irq_n === 1'b0, "R9 above threshold", {7'b0, irq_n}, 8'h00);
    rd(4'd0, 8'h40, "R9 status move");
    rd_nav(8'h28, 8'h0B, 8'h03, "R6 packet");

    mov(8'd127, -8'sd100);
    mov(8'd127, -8'sd100);
    mov(8'd2, -8'sd100);
    rd_nav(8'hE8, 8'hFF, 8'hFF, "R8 overflow");
    rd(4'd0, 8'h40, "R8 status move");
    rd_nav(8'h08, 8'h00, 8'h00, "R8 overflow cleared");

    wr(4'd1, 7'h34);
    clk_pulse(); mov(8'd20, 8'd20);
    rd(4'd0, 8'h00, "R13 osc off");
    rd_nav(8'h08, 8'h00, 8'h00, "R13 osc off nav");
    wr(4'd1, 7'h20);
    clk_pulse();
    rd(4'd0, 8'h00, "R13 click mode off");
    wr(4'd1, 7'h30);

    wr(4'd0, 7'h7F);
    rd(4'd0, 8'h00, "R11 status write");
    wr(4'd7, 7'h11);
    rd(4'd1, 8'h30, "R11 reserved write");
    sel(); xfer(8'h55, 0, 0, ""); desel();
    rd(4'd1, 8'h30, "R11 stray data");

    rd(4'd9, 8'h00, "R12 reserved read");
    check(irq_n === 1'b0, "R12 read error irq", {7'b0, irq_n}, 8'h00);
    rd(4'd0, 8'h08, "R12 status read error");
    check(irq_n === 1'b1, "R12 irq released", {7'b0, irq_n}, 8'h01);

    sel(); spi_bits(8'h84, 4, r);
    check(miso_oe === 1'b1, "R2 miso_oe selected", {7'b0, miso_oe}, 8'h01);
    desel();
    sel(); spi_bits(8'h40, 4, r); xfer(8'h20, 0, 0, ""); desel();
    rd(4'd1, 8'h20, "R2 split command");
    sel(); spi_bits(8'hFF, 3, r); desel();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(5);
    rd(4'd1, 8'h04, "R2 resync by reset");

    wait (got_q.size() == 0);
    cyc(2);
    check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule